// File: doc/BRIEF.md
# Banked context store with loop caches

This block holds the adaptive probability contexts for a binary arithmetic decoding core that can retire two bins per clock. Each context is a 7-bit word: a 6-bit probability state in bits 5..0 and the most-probable-symbol value in bit 6. The table is spread over several independent banks. Bank and row come from the context index, so two contexts in different banks can be fetched in the same cycle. The slice-start loader writes one row of every bank per cycle.

Some syntax loops hit the same few contexts again and again. For these, the decoder first names up to four contexts with a loop-start pulse. The block copies them into registers in one cycle, reading each from its own bank. Reads and updates inside the loop then use the registers only. A loop-end pulse writes all of them back to the banks in a single busy cycle, so each such context costs one bank read and one bank write per loop. The computation of the initial values is outside this block.

Top module: `ctx_store`

## Requirements
- R1: With `init_en` high, row r of every bank is written: context r*4+b takes `init_data[b*7 +: 7]` (bit 6 = MPS, bits 5..0 = state). Every cache slot is invalidated, without write-back.
- R2: Context index i lives in bank i%4, row i/4. A request pair accepted at a clock edge (`rq_valid` and `rq_ready` both high) shows `rsp_valid` high in the next cycle, with the two contexts in `rsp0_ctx` and `rsp1_ctx`.
- R3: Two different uncached indices in the same bank hold `rq_ready` low for exactly one cycle. The pair is accepted in the following cycle, provided the requester keeps it stable.
- R4: Indices in different banks, or the same index on both ports, are accepted with no stall.
- R5: An update to an uncached index is written to its bank. A read accepted in the same cycle returns the value from before the update; later reads return the new value.
- R6: A `loop_start` pulse loads the slots enabled in `loop_mask` with the contexts named in `loop_idx`, slot c in bits c*6 +: 6. `rq_ready` is low in that cycle. While a slot is valid, a read of its index returns the slot contents, and the read takes no bank port.
- R7: An update to a cached index changes only the slot. The bank still holds the pre-loop value if the slots are discarded by R1.
- R8: `loop_end`, while any slot is valid, brings one cycle with `busy` high and `rq_ready` low. At the end of that cycle every valid slot is written back and all slots are cleared. With no valid slot, `loop_end` has no effect.
- R9: When both update ports carry the same index in one cycle, the port-1 value is the one kept.
- R10: After reset, with idle inputs, `rq_ready` is high and both `busy` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_en | input | 1 | Write one row of all banks |
| init_row | input | 4 | Row written by the loader |
| init_data | input | 28 | One 7-bit context per bank, bank 0 lowest |
| rq_valid | input | 1 | Read request for a pair of contexts |
| rq0_idx | input | 6 | First context index |
| rq1_idx | input | 6 | Second context index |
| rq_ready | output | 1 | Request accepted at this edge |
| rsp_valid | output | 1 | Response registers hold a new pair |
| rsp0_ctx | output | 7 | Context for `rq0_idx` |
| rsp1_ctx | output | 7 | Context for `rq1_idx` |
| upd0_en | input | 1 | Write back first updated context |
| upd0_idx | input | 6 | Index of first update |
| upd0_ctx | input | 7 | Value of first update |
| upd1_en | input | 1 | Write back second updated context |
| upd1_idx | input | 6 | Index of second update |
| upd1_ctx | input | 7 | Value of second update |
| loop_start | input | 1 | Load the cache slots |
| loop_idx | input | 24 | Four cache indices, slot c in bits c*6 +: 6 |
| loop_mask | input | 4 | Slots to enable |
| loop_end | input | 1 | Write back and clear the slots |
| busy | output | 1 | Write-back cycle in progress |

## Verification
The bench runs a bank collision both with and without a cached partner. A design that stalls on a cached hit, or never releases a stall, stops matching the reference on `rq_ready`. It reads a context in the very cycle it is updated, and updates the same index from both ports at once. A wrong forwarding choice or a wrong port priority shows up in `rsp0_ctx`. A sixteen-pass loop alternates updates to two cached contexts, then reads them after the write-back. It also discards one loop through a slice restart and reads the stale bank word. A design that writes through to the banks, drops the write-back, or keeps serving from stale slots returns the wrong value.

// File: rtl/ctx_store.sv
module ctx_store #(
  parameter int NCTX   = 64,
  parameter int NBANK  = 4,
  parameter int NCACHE = 4,
  parameter int SW     = 6,
  localparam int EW    = SW + 1,
  localparam int IW    = $clog2(NCTX),
  localparam int BW    = $clog2(NBANK),
  localparam int RW    = IW - BW,
  localparam int NROW  = NCTX / NBANK
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_en,
  input  logic [RW-1:0]       init_row,
  input  logic [NBANK*EW-1:0] init_data,
  input  logic                rq_valid,
  input  logic [IW-1:0]       rq0_idx,
  input  logic [IW-1:0]       rq1_idx,
  output logic                rq_ready,
  output logic                rsp_valid,
  output logic [EW-1:0]       rsp0_ctx,
  output logic [EW-1:0]       rsp1_ctx,
  input  logic                upd0_en,
  input  logic [IW-1:0]       upd0_idx,
  input  logic [EW-1:0]       upd0_ctx,
  input  logic                upd1_en,
  input  logic [IW-1:0]       upd1_idx,
  input  logic [EW-1:0]       upd1_ctx,
  input  logic                loop_start,
  input  logic [NCACHE*IW-1:0] loop_idx,
  input  logic [NCACHE-1:0]   loop_mask,
  input  logic                loop_end,
  output logic                busy
);

  logic [EW-1:0] mem [NBANK][NROW];
  logic [NCACHE-1:0] cv;
  logic [IW-1:0] ci [NCACHE];
  logic [EW-1:0] cd [NCACHE];
  logic wb, phase;
  logic [EW-1:0] hold0, rv0, rv1;
  logic hit0, hit1, uhit0, uhit1;

  always_comb begin
    hit0 = 1'b0; hit1 = 1'b0; uhit0 = 1'b0; uhit1 = 1'b0;
    rv0 = mem[rq0_idx[BW-1:0]][rq0_idx[IW-1:BW]];
    rv1 = mem[rq1_idx[BW-1:0]][rq1_idx[IW-1:BW]];
    for (int c = 0; c < NCACHE; c++) begin
      if (cv[c]) begin
        if (ci[c] == rq0_idx) begin hit0 = 1'b1; rv0 = cd[c]; end
        if (ci[c] == rq1_idx) begin hit1 = 1'b1; rv1 = cd[c]; end
        if (ci[c] == upd0_idx) uhit0 = 1'b1;
        if (ci[c] == upd1_idx) uhit1 = 1'b1;
      end
    end
  end

  wire collide = rq_valid && rq0_idx[BW-1:0] == rq1_idx[BW-1:0] &&
                 rq0_idx != rq1_idx && !hit0 && !hit1;
  wire stall1  = collide && !phase && !wb && !loop_start;
  assign rq_ready = !wb && !loop_start && !(collide && !phase);
  assign busy = wb;
  wire accept = rq_valid && rq_ready;

  always_ff @(posedge clk) begin
    if (init_en)
      for (int b = 0; b < NBANK; b++) mem[b][init_row] <= init_data[b*EW +: EW];
    if (upd0_en && !uhit0) mem[upd0_idx[BW-1:0]][upd0_idx[IW-1:BW]] <= upd0_ctx;
    if (upd1_en && !uhit1) mem[upd1_idx[BW-1:0]][upd1_idx[IW-1:BW]] <= upd1_ctx;
    if (wb)
      for (int c = 0; c < NCACHE; c++)
        if (cv[c]) mem[ci[c][BW-1:0]][ci[c][IW-1:BW]] <= cd[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv <= '0;
      for (int c = 0; c < NCACHE; c++) begin ci[c] <= '0; cd[c] <= '0; end
    end else if (init_en) begin
      cv <= '0;
    end else if (loop_start) begin
      cv <= loop_mask;
      for (int c = 0; c < NCACHE; c++) begin
        ci[c] <= loop_idx[c*IW +: IW];
        cd[c] <= mem[loop_idx[c*IW +: BW]][loop_idx[c*IW+BW +: RW]];
      end
    end else if (wb) begin
      cv <= '0;
    end else begin
      for (int c = 0; c < NCACHE; c++) begin
        if (cv[c] && upd0_en && ci[c] == upd0_idx) cd[c] <= upd0_ctx;
        if (cv[c] && upd1_en && ci[c] == upd1_idx) cd[c] <= upd1_ctx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb <= 1'b0; phase <= 1'b0; hold0 <= '0;
      rsp_valid <= 1'b0; rsp0_ctx <= '0; rsp1_ctx <= '0;
    end else begin
      wb <= loop_end && (|cv);
      rsp_valid <= accept;
      if (stall1) begin phase <= 1'b1; hold0 <= rv0; end
      else if (accept) phase <= 1'b0;
      if (accept) begin
        rsp0_ctx <= phase ? hold0 : rv0;
        rsp1_ctx <= rv1;
      end
    end
  end

  // R2
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && rq_ready |=> rsp_valid);
  // R3
  stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase && !wb && !loop_start |=> !phase);
  // R8
  wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb |=> !wb);
  // R8
  busy_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rq_ready);
  // R8
  slots_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb && !loop_start && !init_en |=> cv == '0);

endmodule

// File: tb/ctx_store_test.sv
module ctx_store_test;
  localparam int NCTX = 64, NB = 4, NC = 4, EW = 7, IW = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, init_en, rq_valid, upd0_en, upd1_en, loop_start, loop_end;
  logic [3:0] init_row;
  logic [NB*EW-1:0] init_data;
  logic [IW-1:0] rq0_idx, rq1_idx, upd0_idx, upd1_idx;
  logic [EW-1:0] upd0_ctx, upd1_ctx;
  logic [NC*IW-1:0] loop_idx;
  logic [NC-1:0] loop_mask;
  logic rq_ready, rsp_valid, busy;
  logic [EW-1:0] rsp0_ctx, rsp1_ctx;

  ctx_store uut (.clk(clk), .rst_n(rst_n), .init_en(init_en), .init_row(init_row),
    .init_data(init_data), .rq_valid(rq_valid), .rq0_idx(rq0_idx), .rq1_idx(rq1_idx),
    .rq_ready(rq_ready), .rsp_valid(rsp_valid), .rsp0_ctx(rsp0_ctx), .rsp1_ctx(rsp1_ctx),
    .upd0_en(upd0_en), .upd0_idx(upd0_idx), .upd0_ctx(upd0_ctx), .upd1_en(upd1_en),
    .upd1_idx(upd1_idx), .upd1_ctx(upd1_ctx), .loop_start(loop_start), .loop_idx(loop_idx),
    .loop_mask(loop_mask), .loop_end(loop_end), .busy(busy));

  int m_mem [NCTX];
  bit m_cv [NC];
  int m_ci [NC], m_cd [NC];
  bit m_ph, m_wb, m_acc, e_rv;
  int m_hold, e_r0, e_r1;
  int errs = 0, checks = 0;
  string tag = "R10";
  bit done = 0;

  task automatic chk(string what, logic [31:0] act, int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int look(int i, output bit h);
    h = 0; look = m_mem[i];
    for (int c = 0; c < NC; c++) if (m_cv[c] && m_ci[c] == i) begin h = 1; look = m_cd[c]; end
  endfunction

  task automatic tick();
    bit h0, h1, uh0, uh1, col, rdy, st1, anyv;
    int v0, v1, ld [NC];
    @(negedge clk);
    v0 = look(int'(rq0_idx), h0); v1 = look(int'(rq1_idx), h1);
    col = rq_valid && (rq0_idx % NB == rq1_idx % NB) && rq0_idx != rq1_idx && !h0 && !h1;
    rdy = !m_wb && !loop_start && !(col && !m_ph);
    chk("rq_ready", rq_ready, rdy);
    chk("busy", busy, m_wb);
    m_acc = rq_valid && rdy;
    st1 = col && !m_ph && !m_wb && !loop_start;
    if (m_acc) begin e_r0 = m_ph ? m_hold : v0; e_r1 = v1; end
    e_rv = m_acc;
    if (st1) m_hold = v0;
    m_ph = st1 ? 1'b1 : (m_acc ? 1'b0 : m_ph);
    void'(look(int'(upd0_idx), uh0)); void'(look(int'(upd1_idx), uh1));
    anyv = 0;
    for (int c = 0; c < NC; c++) begin
      anyv |= m_cv[c];
      ld[c] = m_mem[loop_idx[c*IW +: IW]];
    end
    if (init_en) for (int b = 0; b < NB; b++) m_mem[init_row*NB + b] = init_data[b*EW +: EW];
    if (upd0_en && !uh0) m_mem[upd0_idx] = upd0_ctx;
    if (upd1_en && !uh1) m_mem[upd1_idx] = upd1_ctx;
    if (m_wb) for (int c = 0; c < NC; c++) if (m_cv[c]) m_mem[m_ci[c]] = m_cd[c];
    if (init_en) for (int c = 0; c < NC; c++) m_cv[c] = 0;
    else if (loop_start)
      for (int c = 0; c < NC; c++) begin
        m_cv[c] = loop_mask[c]; m_ci[c] = loop_idx[c*IW +: IW]; m_cd[c] = ld[c];
      end
    else if (m_wb) for (int c = 0; c < NC; c++) m_cv[c] = 0;
    else for (int c = 0; c < NC; c++) if (m_cv[c]) begin
      if (upd0_en && m_ci[c] == upd0_idx) m_cd[c] = upd0_ctx;
      if (upd1_en && m_ci[c] == upd1_idx) m_cd[c] = upd1_ctx;
    end
    m_wb = loop_end && anyv;
    @(posedge clk); #1;
    chk("rsp_valid", rsp_valid, e_rv);
    if (e_rv) begin chk("rsp0_ctx", rsp0_ctx, e_r0); chk("rsp1_ctx", rsp1_ctx, e_r1); end
  endtask

  task automatic idle();
    init_en = 0; rq_valid = 0; upd0_en = 0; upd1_en = 0; loop_start = 0; loop_end = 0;
  endtask

  task automatic request(int a, int b);
    rq_valid = 1; rq0_idx = a[IW-1:0]; rq1_idx = b[IW-1:0];
    for (int k = 0; k < 4; k++) begin tick(); if (m_acc) break; end
    rq_valid = 0;
  endtask

  task automatic open_loop(int a, int b, int c, int d, int mask);
    loop_start = 1; loop_mask = mask[NC-1:0];
    loop_idx = {d[IW-1:0], c[IW-1:0], b[IW-1:0], a[IW-1:0]};
    tick(); loop_start = 0;
  endtask

  initial begin
    #(8 * 200000);
    errs++; checks++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); init_row = 0; init_data = 0; rq0_idx = 0; rq1_idx = 0;
    upd0_idx = 0; upd1_idx = 0; upd0_ctx = 0; upd1_ctx = 0; loop_idx = 0; loop_mask = 0;
    m_ph = 0; m_wb = 0; m_hold = 0; e_rv = 0; e_r0 = 0; e_r1 = 0;
    for (int c = 0; c < NC; c++) begin m_cv[c] = 0; m_ci[c] = 0; m_cd[c] = 0; end
    for (int i = 0; i < NCTX; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R10"; tick(); tick();

    tag = "R1";
    for (int r = 0; r < NCTX / NB; r++) begin
      init_en = 1; init_row = r[3:0];
      for (int b = 0; b < NB; b++) init_data[b*EW +: EW] = 7'((r*NB + b) * 37 + 5);
      tick();
    end
    idle();

    tag = "R2"; request(0, 1); request(5, 10); request(63, 2); tick(); request(22, 49);
    tag = "R4"; request(7, 7); request(13, 14);
    tag = "R3"; request(4, 8); request(61, 1); request(33, 53);

    tag = "R5";
    upd0_en = 1; upd0_idx = 9; upd0_ctx = 7'h55; rq_valid = 1; rq0_idx = 9; rq1_idx = 10;
    tick(); idle(); request(9, 11);

    tag = "R9";
    upd0_en = 1; upd0_idx = 12; upd0_ctx = 7'h11; upd1_en = 1; upd1_idx = 12; upd1_ctx = 7'h6a;
    tick(); idle(); request(12, 12);

    tag = "R6";
    open_loop(20, 21, 22, 23, 4'hf);
    request(20, 23); request(21, 22); request(20, 24);

    tag = "R7";
    for (int k = 0; k < 16; k++) begin
      upd0_en = 1; upd0_idx = 21; upd0_ctx = 7'(k * 3 + 1);
      upd1_en = 1; upd1_idx = 22; upd1_ctx = 7'(k * 5 + 64);
      rq_valid = 1; rq0_idx = 21; rq1_idx = 22;
      tick();
    end
    idle();

    tag = "R8";
    loop_end = 1; tick(); loop_end = 0;
    request(21, 22); request(20, 23);
    loop_end = 1; tick(); loop_end = 0; tick();

    tag = "R6"; open_loop(40, 41, 0, 0, 4'h3); request(40, 44);
    loop_end = 1; tick(); loop_end = 0; tick();

    tag = "R7";
    open_loop(30, 33, 0, 0, 4'h3);
    upd0_en = 1; upd0_idx = 30; upd0_ctx = 7'h7f; tick(); idle();
    request(30, 33);
    tag = "R1";
    init_en = 1; init_row = 0; init_data = {7'd1, 7'd2, 7'd3, 7'd4}; tick(); idle();
    loop_end = 1; tick(); loop_end = 0;
    tag = "R7"; request(30, 33); request(0, 3);

    tick(); tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule